// File: doc/BRIEF.md
# Strobe-Latched Serial LED Driver Register

This block turns a three-wire serial stream into a wide bank of steady LED drive levels. A controller shifts one bit in on every rising edge of the shift clock. After a full frame of `WIDTH` bits it pulls the active-low strobe down, and the output bank takes the new pattern. While the strobe stays high, the outputs keep their last pattern however much data moves through the chain. This lets a new frame be shifted in without the LEDs flickering.

In this synchronous model the output bank is a register. It reloads from the post-shift chain on every clock edge at which the strobe is low. With the strobe held low, the outputs therefore track the chain one shift at a time. An active-low clear forces every output bit to the fill level (all ones by default) at once, without waiting for a clock edge. The clear overrides the strobe, and it never disturbs the chain. The last chain stage leaves the block as a cascade output, so several blocks can be chained into a longer string.

Top module: `sipo_led_driver`

## Requirements
- R1: On every rising clock edge the chain shifts by one stage. The cascade output `ser_out` shows the bit that entered `WIDTH` edges earlier.
- R2: After `WIDTH` shifts, the first bit shifted in sits at `par_out[WIDTH-1]` and the most recent bit at `par_out[0]`. This holds when the strobe is low on the edge of the last bit.
- R3: When `stb_n` is 0 and `clr_n` is 1 at a rising edge, `par_out` equals the chain contents after that edge. The outputs change after every shift while the strobe stays low.
- R4: When `stb_n` is 1 and `clr_n` is 1 at a rising edge, `par_out` keeps its value across that edge.
- R5: While `clr_n` is 0, every bit of `par_out` is 1 (default fill), whatever the value of `stb_n`. It changes at once, with no clock edge needed.
- R6: The clear does not alter the chain. Bits shifted during a clear, and the bits before them, appear at `par_out` once the clear is released and the strobe is asserted.
- R7: `ser_out` is the last chain stage. It changes only on a rising clock edge and does not depend on `stb_n` or `clr_n`.
- R8: While `rst_n` is 0, the chain is all zeros, `ser_out` is 0 and `par_out` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of chain and output bank |
| ser_in | input | 1 | Serial data input |
| stb_n | input | 1 | Active-low strobe; output bank loads while low |
| clr_n | input | 1 | Active-low asynchronous clear of the output bank |
| par_out | output | WIDTH | Parallel outputs; bit 0 holds the newest bit |
| ser_out | output | 1 | Cascade output, last chain stage |

## Verification
The bench builds the block with its default 24-stage depth and the all-ones clear fill. This makes the full first-in-to-last-output ordering and the 24-edge delay to the cascade output directly observable. With that depth, random strobe and clear patterns reach long runs of held outputs, transparent tracking and clears that overlap shifting, all within a few hundred cycles. Directed cases cover the clear arriving between clock edges and the clear combined with the strobe.

// File: rtl/sled_pkg.sv
package sled_pkg;
   // Level taken by every output bit while the clear is asserted
   typedef enum logic {
      FILL_ONES  = 1'b1,
      FILL_ZEROS = 1'b0
   } fill_e;

   localparam int unsigned SLED_MIN_WIDTH = 2;
   localparam int unsigned SLED_MAX_WIDTH = 1024;
endpackage

// File: rtl/sled_shift_chain.sv
module sled_shift_chain #(
   parameter int unsigned WIDTH = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   output logic [WIDTH-1:0] chain_q,
   output logic [WIDTH-1:0] chain_d
);
   localparam int unsigned TOP = WIDTH - 1;

   // Newest bit enters stage 0, oldest leaves from stage TOP
   assign chain_d = {chain_q[TOP-1:0], din};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
   end
endmodule

// File: rtl/sled_latch_bank.sv
module sled_latch_bank
   import sled_pkg::*;
#(
   parameter int unsigned WIDTH    = 24,
   parameter fill_e       CLR_FILL = FILL_ONES
) (
   input  logic             clk,
   input  logic             preset_n,
   input  logic             stb_n,
   input  logic [WIDTH-1:0] load_val,
   output logic [WIDTH-1:0] lat_q
);
   localparam logic FILL_BIT = logic'(CLR_FILL);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic bit_q;
      if (FILL_BIT) begin : g_set
         always_ff @(posedge clk or negedge preset_n) begin
            if (!preset_n)   bit_q <= 1'b1;
            else if (!stb_n) bit_q <= load_val[i];
         end
      end else begin : g_rst
         always_ff @(posedge clk or negedge preset_n) begin
            if (!preset_n)   bit_q <= 1'b0;
            else if (!stb_n) bit_q <= load_val[i];
         end
      end
      assign lat_q[i] = bit_q;
   end
endmodule

// File: rtl/sipo_led_driver.sv
module sipo_led_driver
   import sled_pkg::*;
#(
   parameter int unsigned WIDTH    = 24,
   parameter fill_e       CLR_FILL = FILL_ONES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_in,
   input  logic             stb_n,
   input  logic             clr_n,
   output logic [WIDTH-1:0] par_out,
   output logic             ser_out
);
   localparam int unsigned LAST = WIDTH - 1;

   if (WIDTH < SLED_MIN_WIDTH || WIDTH > SLED_MAX_WIDTH) begin : g_bad_width
      $error("sipo_led_driver: WIDTH out of range");
   end

   logic [WIDTH-1:0] chain_q;
   logic [WIDTH-1:0] chain_d;
   logic             bank_preset_n;

   // Power-on reset and the functional clear both preset the bank
   assign bank_preset_n = rst_n & clr_n;

   sled_shift_chain #(.WIDTH(WIDTH)) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (ser_in),
      .chain_q (chain_q),
      .chain_d (chain_d)
   );

   // Bank loads the post-shift value, so it is transparent to each shift
   sled_latch_bank #(.WIDTH(WIDTH), .CLR_FILL(CLR_FILL)) u_bank (
      .clk      (clk),
      .preset_n (bank_preset_n),
      .stb_n    (stb_n),
      .load_val (chain_d),
      .lat_q    (par_out)
   );

   assign ser_out = chain_q[LAST];
endmodule

// File: rtl/sled_checker.sv
module sled_checker
   import sled_pkg::*;
#(
   parameter int unsigned WIDTH    = 24,
   parameter fill_e       CLR_FILL = FILL_ONES
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ser_in,
   input logic             stb_n,
   input logic             clr_n,
   input logic [WIDTH-1:0] par_out,
   input logic             ser_out,
   input logic [WIDTH-1:0] chain_q
);
   localparam logic [WIDTH-1:0] FILL_VEC = {WIDTH{logic'(CLR_FILL)}};

   a_r1_shift: assert property (@(posedge clk) disable iff (!rst_n)
      chain_q[WIDTH-1:1] == $past(chain_q[WIDTH-2:0]));

   a_r2_entry: assert property (@(posedge clk) disable iff (!rst_n)
      chain_q[0] == $past(ser_in));

   a_r3_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb_n && clr_n) |=> (!clr_n || par_out == chain_q));

   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_n && clr_n) |=> (!clr_n || $stable(par_out)));

   a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> par_out == FILL_VEC);

   a_r6_chain_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |=> chain_q[WIDTH-1:1] == $past(chain_q[WIDTH-2:0]));

   a_r7_cascade: assert property (@(posedge clk) disable iff (!rst_n)
      ser_out == $past(chain_q[WIDTH-2]));

   a_r8_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ser_out == 1'b0 && par_out == {WIDTH{1'b1}}));
endmodule

bind sipo_led_driver sled_checker #(.WIDTH(WIDTH), .CLR_FILL(CLR_FILL)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ser_in  (ser_in),
   .stb_n   (stb_n),
   .clr_n   (clr_n),
   .par_out (par_out),
   .ser_out (ser_out),
   .chain_q (chain_q)
);

// File: tb/sipo_led_driver_test.sv
module sipo_led_driver_test;
   localparam int W = 24;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ser_in = 1'b0;
   logic         stb_n = 1'b1;
   logic         clr_n = 1'b1;
   logic [W-1:0] par_out;
   logic         ser_out;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [W-1:0] m_chain;
   logic [W-1:0] m_lat;

   always #5 clk = ~clk;

   sipo_led_driver #(.WIDTH(W)) uut (
      .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .stb_n(stb_n),
      .clr_n(clr_n), .par_out(par_out), .ser_out(ser_out)
   );

   function automatic logic [W-1:0] all_ones();
      return {W{1'b1}};
   endfunction

   function automatic logic [W-1:0] shifted(logic [W-1:0] c, logic d);
      return {c[W-2:0], d};
   endfunction

   task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One clock: drive at the falling edge, update model at the rising edge,
   // compare shortly after it.
   task automatic cyc(logic d, logic s, logic c);
      @(negedge clk);
      ser_in = d; stb_n = s; clr_n = c;
      @(posedge clk);
      m_chain = shifted(m_chain, d);
      if (!c)      m_lat = all_ones();
      else if (!s) m_lat = m_chain;
      #2;
      if (!c)      check("R5 clear", par_out, m_lat);
      else if (!s) check("R3 follow", par_out, m_lat);
      else         check("R4 hold", par_out, m_lat);
      check("R7 cascade", W'(ser_out), W'(m_chain[W-1]));
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] pat;
      void'($urandom(32'd2718));
      m_chain = '0;
      m_lat   = all_ones();
      #23;
      // R8 reset state
      check("R8 reset par", par_out, all_ones());
      check("R8 reset so", W'(ser_out), '0);
      @(negedge clk); rst_n = 1'b1;

      // R2 / R1: full frame, strobe on the last bit
      pat = 24'hA5_3C_96;
      for (int k = W - 1; k >= 1; k--) cyc(pat[k], 1'b1, 1'b1);
      check("R4 frame held", par_out, all_ones());
      cyc(pat[0], 1'b0, 1'b1);
      check("R2 order", par_out, pat);
      check("R1 depth", W'(ser_out), W'(pat[W-1]));

      // R4: new frame shifted with strobe high leaves outputs alone
      for (int k = 0; k < W; k++) cyc(k[0], 1'b1, 1'b1);
      check("R4 long hold", par_out, pat);
      check("R1 cascade frame", W'(ser_out), W'(1'b0));

      // R6: shift during clear, then release and strobe
      for (int k = 0; k < 10; k++) cyc(k[1], 1'b1, 1'b0);
      check("R5 during clear", par_out, all_ones());
      cyc(1'b1, 1'b0, 1'b1);
      check("R6 chain kept", par_out, m_chain);

      // R5: clear wins over strobe
      cyc(1'b0, 1'b0, 1'b0);
      cyc(1'b0, 1'b0, 1'b0);
      check("R5 priority", par_out, all_ones());
      cyc(1'b0, 1'b0, 1'b1);

      // R5: clear between edges takes effect without a clock
      @(negedge clk);
      ser_in = 1'b1; stb_n = 1'b1; clr_n = 1'b1;
      #2 clr_n = 1'b0;
      #1 check("R5 async", par_out, all_ones());
      @(posedge clk);
      m_chain = shifted(m_chain, 1'b1);
      m_lat   = all_ones();
      cyc(1'b0, 1'b0, 1'b1);
      check("R3 after async clear", par_out, m_chain);

      // Random mix
      for (int n = 0; n < 600; n++) begin
         logic d, s, c;
         d = 1'($urandom);
         s = ($urandom % 10) < 4 ? 1'b0 : 1'b1;
         c = ($urandom % 10) == 0 ? 1'b0 : 1'b1;
         cyc(d, s, c);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule